// File: doc/BRIEF.md
# CAM Match Status Register Unit

A small content-addressable memory core that keeps a 64-bit search key (the comparand), a bank of 16 stored 64-bit entries each with a valid bit and a skip bit, and a 32-bit status word. The comparand is written 32 bits at a time, and a segment pointer selects which half a write lands in and which half is shown on the read port. A learn operation copies the whole comparand into the lowest-numbered empty entry. A compare operation checks the comparand against every entry that is valid and not skipped, all in one clock cycle.

The status word reports the result of the most recent compare as active-low flags: a match flag, a multiple-match flag, and the address of the highest-priority hit. The highest-priority hit is the lowest-numbered matching entry. The status word also carries an active-low full flag, the skip and empty bits of the entry most recently read, and a page identifier supplied from outside. A separate output gives the next-free address, which is the lowest-numbered empty entry.

Operations arrive as a one-cycle strobe with a 3-bit code, an entry address and a 32-bit data word. Every operation takes effect at the clock edge that samples it.

Top module: `cam_status_unit`

## Requirements
- R1: After reset, the status word reads match bit 31 = 1, multiple-match bit 30 = 1, full bit 29 = 1, skip bit 28 = 1, empty bit 27 = 1, and match address bits [3:0] = 4'hF. At the same time the next-free address is 0, the comparand is zero, and the segment pointer is 0.
- R2: Op code 1 (segment select) loads the segment pointer from data bit 0. Op code 2 (comparand write) writes the 32-bit data word into the comparand segment the pointer selects. Segment 1 holds comparand bits [63:32]. The comparand read port always shows the selected segment.
- R3: Op code 4 (learn) stores the full comparand into the entry at the next-free address, sets its valid bit and clears its skip bit. From the cycle after the learn edge, the next-free address is the lowest-numbered entry whose valid bit is clear.
- R4: When all entries are valid, full bit 29 reads 0 and the next-free address reads 0. A learn issued while full changes no entry.
- R5: Op code 3 (compare) with exactly one eligible hit drives bit 31 to 0, bit 30 to 1, and bits [3:0] to the address of the hit, from the cycle after the compare edge.
- R6: A compare with two or more eligible hits drives bits 31 and 30 to 0, and bits [3:0] to the lowest hit address.
- R7: A compare with no eligible hit drives bits 31 and 30 to 1 and bits [3:0] to all ones.
- R8: A compare counts only entries that are valid and have their skip bit clear. Op code 6 sets an entry's skip bit from data bit 0.
- R9: Op code 5 (entry read) presents the addressed entry's 64-bit contents on the entry data port. It also sets status bit 28 to that entry's skip bit and status bit 27 to 1 if the entry was not valid, or 0 if it was.
- R10: Op code 7 (clear) resets the addressed entry's valid and skip bits. The full flag and the next-free address follow from the next cycle.
- R11: Status bits [26:4] show the page identifier input unchanged.
- R12: The match flags and match address hold their last compare result across any operation other than a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 3 | Operation code (see requirements) |
| op_addr | input | 4 | Entry address for read, skip and clear |
| op_wdata | input | 32 | Comparand segment data or control bit |
| page_id | input | 23 | Page identifier placed in the status word |
| status_o | output | 32 | Packed status word |
| next_free_o | output | 4 | Lowest-numbered empty entry |
| cmp_seg_o | output | 32 | Comparand segment selected by the pointer |
| entry_data_o | output | 64 | Contents of the entry last read |

## Verification
The hardest states to reach from the ports are a completely full bank and a multiple match in which a skip bit changes the winner. The stimulus reaches the full bank by learning 16 distinct keys, each built from two segment writes, and then issues one more learn that must be refused. It then clears one entry and re-learns a duplicate of an earlier key, which makes a compare report two hits. Setting the skip bit on the lower hit then moves the reported address to the higher one.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_SEGSEL  = 3'd1,
    OP_CMPWR   = 3'd2,
    OP_COMPARE = 3'd3,
    OP_LEARN   = 3'd4,
    OP_READ    = 3'd5,
    OP_SKIP    = 3'd6,
    OP_CLEAR   = 3'd7
  } cam_op_e;

  localparam int STAT_W    = 32;
  localparam int BIT_MATCH = 31;
  localparam int BIT_MULTI = 30;
  localparam int BIT_FULL  = 29;
  localparam int BIT_SKIP  = 28;
  localparam int BIT_EMPTY = 27;
  localparam int FLAG_BITS = 5;
endpackage

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [AW-1:0] idx,
  output logic          any,
  output logic          many
);
  function automatic logic [AW-1:0] lowest_set(input logic [N-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = i[AW-1:0];
    end
    return r;
  endfunction

  function automatic logic two_or_more(input logic [N-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction

  assign idx  = lowest_set(vec);
  assign any  = |vec;
  assign many = two_or_more(vec);
endmodule

// File: rtl/cam_cmp_reg.sv
module cam_cmp_reg #(
  parameter int SEG_W = 32,
  parameter int NSEG  = 2,
  parameter int SPW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_en,
  input  logic                  wr_en,
  input  logic [SEG_W-1:0]      wdata,
  output logic [SEG_W*NSEG-1:0] comparand,
  output logic [SEG_W-1:0]      seg_rd
);
  logic [SEG_W-1:0] seg_q [NSEG];
  logic [SPW-1:0]   ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (sel_en && (int'(wdata[SPW-1:0]) < NSEG)) begin
      ptr_q <= wdata[SPW-1:0];
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (wr_en && (int'(ptr_q) == g)) begin
        seg_q[g] <= wdata;
      end
    end
    assign comparand[g*SEG_W +: SEG_W] = seg_q[g];
  end

  assign seg_rd = seg_q[ptr_q];
endmodule

// File: rtl/cam_array.sv
module cam_array #(
  parameter int ENTRIES = 16,
  parameter int DW      = 64,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               learn_en,
  input  logic [AW-1:0]      learn_addr,
  input  logic               clear_en,
  input  logic               skip_en,
  input  logic               skip_val,
  input  logic               read_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      comparand,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] skip_vec,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [DW-1:0]      rd_data,
  output logic               rd_skip,
  output logic               rd_empty
);
  logic [DW-1:0] mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g]     <= '0;
        valid_vec[g] <= 1'b0;
        skip_vec[g]  <= 1'b0;
      end else begin
        if (learn_en && (int'(learn_addr) == g)) begin
          mem_q[g]     <= comparand;
          valid_vec[g] <= 1'b1;
          skip_vec[g]  <= 1'b0;
        end else if (clear_en && (int'(addr) == g)) begin
          valid_vec[g] <= 1'b0;
          skip_vec[g]  <= 1'b0;
        end else if (skip_en && (int'(addr) == g)) begin
          skip_vec[g]  <= skip_val;
        end
      end
    end
    assign hit_vec[g] = valid_vec[g] & ~skip_vec[g] & (mem_q[g] == comparand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_skip  <= 1'b1;
      rd_empty <= 1'b1;
    end else if (read_en) begin
      rd_data  <= mem_q[addr];
      rd_skip  <= skip_vec[addr];
      rd_empty <= ~valid_vec[addr];
    end
  end
endmodule

// File: rtl/cam_flags.sv
module cam_flags #(
  parameter int AW     = 4,
  parameter int PAGE_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              hit_any,
  input  logic              hit_many,
  input  logic [AW-1:0]     hit_idx,
  input  logic              full,
  input  logic              rd_skip,
  input  logic              rd_empty,
  input  logic [PAGE_W-1:0] page_id,
  output logic [31:0]       status
);
  logic          match_n_q;
  logic          multi_n_q;
  logic [AW-1:0] maddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_n_q <= 1'b1;
      multi_n_q <= 1'b1;
      maddr_q   <= '1;
    end else if (cmp_en) begin
      match_n_q <= ~hit_any;
      multi_n_q <= ~hit_many;
      maddr_q   <= hit_any ? hit_idx : '1;
    end
  end

  assign status = {match_n_q, multi_n_q, ~full, rd_skip, rd_empty, page_id, maddr_q};
endmodule

// File: rtl/cam_status_unit.sv
module cam_status_unit #(
  parameter int ENTRIES = 16,
  parameter int SEG_W   = 32,
  parameter int NSEG    = 2,
  parameter int AW      = $clog2(ENTRIES),
  parameter int PAGE_W  = 27 - $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [2:0]            op_code,
  input  logic [AW-1:0]         op_addr,
  input  logic [SEG_W-1:0]      op_wdata,
  input  logic [PAGE_W-1:0]     page_id,
  output logic [31:0]           status_o,
  output logic [AW-1:0]         next_free_o,
  output logic [SEG_W-1:0]      cmp_seg_o,
  output logic [SEG_W*NSEG-1:0] entry_data_o
);
  import cam_pkg::*;

  localparam int DW = SEG_W * NSEG;

  cam_op_e op;
  assign op = cam_op_e'(op_code);

  logic               do_sel, do_wr, do_cmp, do_learn, do_read, do_skip, do_clear;
  logic               full, free_any, free_many, hit_any, hit_many;
  logic [AW-1:0]      free_idx, hit_idx;
  logic [ENTRIES-1:0] valid_vec, skip_vec, hit_vec;
  logic [DW-1:0]      comparand;
  logic               rd_skip, rd_empty;

  assign do_sel   = op_valid && (op == OP_SEGSEL);
  assign do_wr    = op_valid && (op == OP_CMPWR);
  assign do_cmp   = op_valid && (op == OP_COMPARE);
  assign do_learn = op_valid && (op == OP_LEARN) && !full;
  assign do_read  = op_valid && (op == OP_READ);
  assign do_skip  = op_valid && (op == OP_SKIP);
  assign do_clear = op_valid && (op == OP_CLEAR);

  cam_cmp_reg #(.SEG_W(SEG_W), .NSEG(NSEG)) u_cmp (
    .clk(clk), .rst_n(rst_n), .sel_en(do_sel), .wr_en(do_wr),
    .wdata(op_wdata), .comparand(comparand), .seg_rd(cmp_seg_o)
  );

  cam_array #(.ENTRIES(ENTRIES), .DW(DW), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .learn_en(do_learn), .learn_addr(next_free_o),
    .clear_en(do_clear), .skip_en(do_skip), .skip_val(op_wdata[0]),
    .read_en(do_read), .addr(op_addr), .comparand(comparand),
    .valid_vec(valid_vec), .skip_vec(skip_vec), .hit_vec(hit_vec),
    .rd_data(entry_data_o), .rd_skip(rd_skip), .rd_empty(rd_empty)
  );

  cam_prio #(.N(ENTRIES), .AW(AW)) u_free (
    .vec(~valid_vec), .idx(free_idx), .any(free_any), .many(free_many)
  );

  cam_prio #(.N(ENTRIES), .AW(AW)) u_hit (
    .vec(hit_vec), .idx(hit_idx), .any(hit_any), .many(hit_many)
  );

  assign full        = ~free_any;
  assign next_free_o = free_idx;

  cam_flags #(.AW(AW), .PAGE_W(PAGE_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .cmp_en(do_cmp), .hit_any(hit_any),
    .hit_many(hit_many), .hit_idx(hit_idx), .full(full),
    .rd_skip(rd_skip), .rd_empty(rd_empty), .page_id(page_id), .status(status_o)
  );

  logic unused_ok;
  assign unused_ok = free_many;
endmodule

// File: rtl/cam_status_chk.sv
module cam_status_chk #(
  parameter int ENTRIES = 16,
  parameter int AW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [2:0]         op_code,
  input logic [AW-1:0]      op_addr,
  input logic [31:0]        status_o,
  input logic [AW-1:0]      next_free_o,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] skip_vec
);
  logic [ENTRIES-1:0] elig_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else        elig_q <= valid_vec & ~skip_vec;
  end

  p_free_is_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[29] |-> !valid_vec[next_free_o]);

  p_learn_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4 && status_o[29]) |=> valid_vec[$past(next_free_o)]);

  p_full_blocks_learn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4 && !status_o[29]) |=> $stable(valid_vec));

  p_multi_has_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[30] |-> !status_o[31]);

  p_nomatch_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31] |-> (status_o[AW-1:0] == '1));

  p_hit_eligible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |=> (status_o[31] || elig_q[status_o[AW-1:0]]));

  p_read_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd5) |=> (status_o[27] == !$past(valid_vec[op_addr])));

  p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == 3'd3) |=> $stable(status_o[31:30]));
endmodule

bind cam_status_unit cam_status_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_addr(op_addr), .status_o(status_o), .next_free_o(next_free_o),
  .valid_vec(valid_vec), .skip_vec(skip_vec)
);

// File: tb/sim_cam_status_unit.sv
`timescale 1ns/1ps
module sim_cam_status_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0;
  logic [2:0]  op_code = 0;
  logic [3:0]  op_addr = 0;
  logic [31:0] op_wdata = 0;
  logic [22:0] page_id = 23'h15A5A5;
  logic [31:0] status_o;
  logic [3:0]  next_free_o;
  logic [31:0] cmp_seg_o;
  logic [63:0] entry_data_o;

  int n_run = 0, n_fail = 0;

  // bench-side model state
  logic [63:0] m_mem [16];
  logic [15:0] m_valid = 0, m_skip = 0;
  logic [63:0] m_cmp = 0;
  logic        m_ptr = 0;
  logic        m_match_n = 1, m_multi_n = 1, m_skipb = 1, m_empb = 1;
  logic [3:0]  m_maddr = 4'hF;
  logic [63:0] m_rd = 0;

  always #2 clk = ~clk;

  cam_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .page_id(page_id),
    .status_o(status_o), .next_free_o(next_free_o), .cmp_seg_o(cmp_seg_o),
    .entry_data_o(entry_data_o)
  );

  function automatic logic [3:0] m_nf();
    for (int i = 0; i < 16; i++) if (!m_valid[i]) return i[3:0];
    return 4'd0;
  endfunction

  function automatic logic [31:0] m_status();
    return {m_match_n, m_multi_n, ~(&m_valid), m_skipb, m_empb, page_id, m_maddr};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {32'd0, status_o}, {32'd0, m_status()});
    chk(req, {60'd0, next_free_o}, {60'd0, m_nf()});
  endtask

  task automatic do_op(input logic [2:0] code, input logic [3:0] a, input logic [31:0] d);
    int cnt;
    logic [15:0] hits;
    @(negedge clk);
    op_valid = 1; op_code = code; op_addr = a; op_wdata = d;
    @(negedge clk);
    op_valid = 0;
    case (code)
      3'd1: m_ptr = d[0];
      3'd2: if (m_ptr) m_cmp[63:32] = d; else m_cmp[31:0] = d;
      3'd3: begin
        hits = '0; cnt = 0;
        for (int i = 0; i < 16; i++)
          if (m_valid[i] && !m_skip[i] && m_mem[i] == m_cmp) begin hits[i] = 1; cnt++; end
        m_match_n = (cnt == 0); m_multi_n = (cnt < 2); m_maddr = 4'hF;
        for (int i = 15; i >= 0; i--) if (hits[i]) m_maddr = i[3:0];
      end
      3'd4: if (!(&m_valid)) begin
        automatic logic [3:0] f = m_nf();
        m_mem[f] = m_cmp; m_valid[f] = 1; m_skip[f] = 0;
      end
      3'd5: begin m_rd = m_mem[a]; m_skipb = m_skip[a]; m_empb = !m_valid[a]; end
      3'd6: m_skip[a] = d[0];
      3'd7: begin m_valid[a] = 0; m_skip[a] = 0; end
      default: ;
    endcase
  endtask

  function automatic logic [63:0] key(input int i);
    return {32'hB000_0000 + 32'(i * 3), 32'hA000_0000 + 32'(i)};
  endfunction

  task automatic set_cmp(input logic [63:0] k);
    do_op(3'd1, 0, 0); do_op(3'd2, 0, k[31:0]);
    do_op(3'd1, 0, 1); do_op(3'd2, 0, k[63:32]);
  endtask

  task automatic t_reset();
    chk("R1 status", {32'd0, status_o}, {32'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, page_id, 4'hF});
    chk("R1 next free", {60'd0, next_free_o}, 64'd0);
    chk("R1 comparand", {32'd0, cmp_seg_o}, 64'd0);
  endtask

  task automatic t_segments();
    do_op(3'd1, 0, 1); do_op(3'd2, 0, 32'hDEAD_BEEF);
    chk("R2 seg1 view", {32'd0, cmp_seg_o}, 64'hDEAD_BEEF);
    do_op(3'd1, 0, 0);
    chk("R2 seg0 view", {32'd0, cmp_seg_o}, 64'd0);
    do_op(3'd2, 0, 32'h1234_5678);
    chk("R2 seg0 write", {32'd0, cmp_seg_o}, 64'h1234_5678);
    chk("R2 model cmp", m_cmp, 64'hDEAD_BEEF_1234_5678);
  endtask

  task automatic t_learn_single();
    for (int i = 0; i < 3; i++) begin
      set_cmp(key(i)); do_op(3'd4, 0, 0);
      chk_all("R3 learn");
    end
    chk("R3 nf after 3", {60'd0, next_free_o}, 64'd3);
    set_cmp(key(1)); do_op(3'd3, 0, 0);
    chk_all("R5 single match");
    chk("R5 addr", {60'd0, status_o[3:0]}, 64'd1);
    do_op(3'd0, 0, 0); do_op(3'd5, 0, 0);
    chk("R12 flags hold", {62'd0, status_o[31:30]}, {62'd0, 2'b01});
  endtask

  task automatic t_fill();
    for (int i = 3; i < 16; i++) begin set_cmp(key(i)); do_op(3'd4, 0, 0); end
    chk_all("R4 full");
    chk("R4 full bit", {63'd0, status_o[29]}, 64'd0);
    set_cmp(64'hFFFF_0000_FFFF_0000); do_op(3'd4, 0, 0);
    do_op(3'd5, 0, 0);
    chk("R4 entry0 kept", entry_data_o, key(0));
    do_op(3'd5, 15, 0);
    chk("R4 entry15 kept", entry_data_o, key(15));
    chk_all("R9 read valid");
  endtask

  task automatic t_multi_skip();
    do_op(3'd7, 5, 0);
    chk_all("R10 clear");
    chk("R10 nf", {60'd0, next_free_o}, 64'd5);
    set_cmp(key(2)); do_op(3'd4, 0, 0);
    do_op(3'd3, 0, 0);
    chk_all("R6 multi");
    chk("R6 addr", {60'd0, status_o[3:0]}, 64'd2);
    do_op(3'd6, 2, 1); do_op(3'd3, 0, 0);
    chk_all("R8 skip");
    chk("R8 addr", {60'd0, status_o[3:0]}, 64'd5);
    do_op(3'd5, 2, 0);
    chk("R9 skip bit", {63'd0, status_o[28]}, 64'd1);
    do_op(3'd7, 9, 0); set_cmp(key(9)); do_op(3'd3, 0, 0);
    chk_all("R8 invalid ignored");
  endtask

  task automatic t_nomatch();
    set_cmp(64'h0123_4567_89AB_CDEF); do_op(3'd3, 0, 0);
    chk_all("R7 no match");
    chk("R7 addr", {60'd0, status_o[3:0]}, 64'hF);
  endtask

  task automatic t_read_empty();
    do_op(3'd5, 9, 0);
    chk_all("R9 empty read");
    chk("R9 empty bit", {63'd0, status_o[27]}, 64'd1);
    chk("R9 data", entry_data_o, key(9));
  endtask

  task automatic t_page();
    page_id = 23'h2C3D4E; #1;
    chk("R11 page", {41'd0, status_o[26:4]}, {41'd0, 23'h2C3D4E});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_segments();
    t_learn_single();
    t_fill();
    t_multi_skip();
    t_nomatch();
    t_read_empty();
    t_page();
    finish_run();
  end
endmodule